// File: doc/BRIEF.md
# Steepest-Descent Direction Mask Unit

This unit performs the set-up pass of a hill-climbing watershed segmentation. Each accepted transfer carries one pixel: its grey level and the grey levels of its four grid neighbours. The unit measures the drop from the pixel to every neighbour that is present and strictly lower. It then marks, in a 4-bit direction mask, every neighbour whose drop equals the largest drop. It also raises a flag when no present neighbour lies below the pixel. In the later flooding pass, the mask decides which neighbours are allowed to trigger the pixel.

Pixels enter through a valid/ready handshake. Results leave two cycles later through a second valid/ready handshake. Each of the two pipeline slots is a small two-state machine. SLOT_IDLE moves to SLOT_BUSY when the slot loads a valid item (transition LOAD). SLOT_BUSY moves back to SLOT_IDLE when the slot advances with nothing behind it (transition DRAIN). Both states stay where they are while the pipeline is frozen (transition HOLD). The pipeline advances whenever the output register is empty or is being consumed.

Top module: `steep_mask_unit`

## Requirements
- R1: The drop to a neighbour is the pixel's grey level minus the neighbour's. A mask bit is set only for a present, strictly lower neighbour whose drop equals the largest drop among present, strictly lower neighbours.
- R2: When several neighbours tie at the largest drop, every one of them has its mask bit set.
- R3: Mask bits and the `nbr_ok` bits follow the order {north, south, west, east}, with north at bit 3 and east at bit 0.
- R4: When no present neighbour is strictly lower, `out_is_min` is 1 and `out_mask` is 0. Otherwise `out_is_min` is 0 and `out_mask` is nonzero.
- R5: A neighbour with a grey level equal to the pixel's counts as not lower.
- R6: A neighbour whose `nbr_ok` bit is 0 is excluded and never sets a mask bit.
- R7: While `out_ready` stays high, the result for a pixel accepted at a clock edge appears on the outputs two edges later.
- R8: While `out_valid` is high and `out_ready` is low, the outputs hold steady. Results leave in acceptance order, and none is lost or duplicated.
- R9: `in_ready` equals the inverse of `out_valid`, ORed with `out_ready`.
- R10: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Pixel transfer offered |
| in_ready | output | 1 | Unit can take a pixel |
| centre | input | PIX_W | Grey level of the pixel |
| nbr_n | input | PIX_W | North neighbour grey level |
| nbr_s | input | PIX_W | South neighbour grey level |
| nbr_w | input | PIX_W | West neighbour grey level |
| nbr_e | input | PIX_W | East neighbour grey level |
| nbr_ok | input | 4 | Neighbour present flags {N,S,W,E} |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_mask | output | 4 | Steepest-descent mask {N,S,W,E} |
| out_is_min | output | 1 | Pixel is a local minimum |

## Verification
A result is due two edges after its pixel is accepted: one edge to register the drops and one to register the mask. When `out_ready` is held high, the bench records the cycle in which each pixel is accepted and requires the result to appear exactly two cycles later. Under backpressure the result may arrive later than that. There, order and value are checked through a queue of expected results, and stability is checked in every stalled cycle. Inputs are driven and outputs sampled between clock edges. Acceptance is decided from `in_ready` after it has settled, so every comparison lands in the cycle where the registered output is already visible.

// File: rtl/smu_pkg.sv
package smu_pkg;
    localparam int NDIR = 4;
    localparam int DIR_N = 3;
    localparam int DIR_S = 2;
    localparam int DIR_W = 1;
    localparam int DIR_E = 0;

    typedef enum logic {
        SLOT_IDLE,
        SLOT_BUSY
    } slot_e;
endpackage

// File: rtl/smu_drop_stage.sv
module smu_drop_stage
    import smu_pkg::*;
#(
    parameter int PIX_W = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        adv,
    input  logic                        in_v,
    input  logic [PIX_W-1:0]            centre,
    input  logic [NDIR-1:0][PIX_W-1:0]  nbr,
    input  logic [NDIR-1:0]             nbr_ok,
    output logic                        v,
    output logic [NDIR-1:0][PIX_W-1:0]  drop,
    output logic [NDIR-1:0]             lower
);
    slot_e state, state_nx;
    logic [NDIR-1:0][PIX_W-1:0] drop_c;
    logic [NDIR-1:0]            lower_c;

    // next-state: LOAD, DRAIN or HOLD
    always_comb begin
        state_nx = state;
        unique case (state)
            SLOT_IDLE: if (adv && in_v)  state_nx = SLOT_BUSY;
            SLOT_BUSY: if (adv && !in_v) state_nx = SLOT_IDLE;
            default:   state_nx = SLOT_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= SLOT_IDLE;
        else        state <= state_nx;
    end

    for (genvar d = 0; d < NDIR; d++) begin : g_dir
        assign lower_c[d] = nbr_ok[d] && (nbr[d] < centre);
        assign drop_c[d]  = centre - nbr[d];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drop  <= '0;
            lower <= '0;
        end else if (adv) begin
            drop  <= drop_c;
            lower <= lower_c;
        end
    end

    always_comb v = (state == SLOT_BUSY);
endmodule

// File: rtl/smu_pick_stage.sv
module smu_pick_stage
    import smu_pkg::*;
#(
    parameter int PIX_W = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        adv,
    input  logic                        in_v,
    input  logic [NDIR-1:0][PIX_W-1:0]  drop,
    input  logic [NDIR-1:0]             lower,
    output logic                        v,
    output logic [NDIR-1:0]             mask,
    output logic                        is_min
);
    slot_e state, state_nx;
    logic [PIX_W-1:0] peak;
    logic [NDIR-1:0]  mask_c;

    always_comb begin
        state_nx = state;
        unique case (state)
            SLOT_IDLE: if (adv && in_v)  state_nx = SLOT_BUSY;
            SLOT_BUSY: if (adv && !in_v) state_nx = SLOT_IDLE;
            default:   state_nx = SLOT_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= SLOT_IDLE;
        else        state <= state_nx;
    end

    // largest drop among strictly lower neighbours
    always_comb begin
        peak = '0;
        for (int d = 0; d < NDIR; d++) begin
            if (lower[d] && drop[d] > peak) peak = drop[d];
        end
    end

    for (genvar d = 0; d < NDIR; d++) begin : g_tie
        assign mask_c[d] = lower[d] && (drop[d] == peak);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask   <= '0;
            is_min <= 1'b0;
        end else if (adv) begin
            mask   <= mask_c;
            is_min <= ~|lower;
        end
    end

    always_comb v = (state == SLOT_BUSY);
endmodule

// File: rtl/steep_mask_unit.sv
module steep_mask_unit
    import smu_pkg::*;
#(
    parameter int PIX_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [PIX_W-1:0]  centre,
    input  logic [PIX_W-1:0]  nbr_n,
    input  logic [PIX_W-1:0]  nbr_s,
    input  logic [PIX_W-1:0]  nbr_w,
    input  logic [PIX_W-1:0]  nbr_e,
    input  logic [3:0]        nbr_ok,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [3:0]        out_mask,
    output logic              out_is_min
);
    logic                        adv;
    logic                        s1_v;
    logic [NDIR-1:0][PIX_W-1:0]  nbr_all;
    logic [NDIR-1:0][PIX_W-1:0]  s1_drop;
    logic [NDIR-1:0]             s1_lower;

    assign nbr_all[DIR_N] = nbr_n;
    assign nbr_all[DIR_S] = nbr_s;
    assign nbr_all[DIR_W] = nbr_w;
    assign nbr_all[DIR_E] = nbr_e;

    assign adv      = !out_valid || out_ready;
    assign in_ready = adv;

    smu_drop_stage #(.PIX_W(PIX_W)) u_drop (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv    (adv),
        .in_v   (in_valid),
        .centre (centre),
        .nbr    (nbr_all),
        .nbr_ok (nbr_ok),
        .v      (s1_v),
        .drop   (s1_drop),
        .lower  (s1_lower)
    );

    smu_pick_stage #(.PIX_W(PIX_W)) u_pick (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv    (adv),
        .in_v   (s1_v),
        .drop   (s1_drop),
        .lower  (s1_lower),
        .v      (out_valid),
        .mask   (out_mask),
        .is_min (out_is_min)
    );
endmodule

// File: rtl/smu_checker.sv
module smu_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic       in_ready,
    input logic       out_valid,
    input logic       out_ready,
    input logic [3:0] out_mask,
    input logic       out_is_min
);
    assert_min_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_is_min) |-> (out_mask == 4'b0000));

    assert_descent_mask_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_is_min) |-> (out_mask != 4'b0000));

    assert_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(in_valid && in_ready, 2) && $past(in_ready, 1)) |-> out_valid);

    assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_mask) && $stable(out_is_min)));

    assert_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_ready |-> in_ready);
endmodule

bind steep_mask_unit smu_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_mask   (out_mask),
    .out_is_min (out_is_min)
);

// File: tb/steep_mask_unit_tb.sv
module steep_mask_unit_tb;
    localparam int W = 3;
    localparam int MAXV = 1 << W;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [W-1:0] centre = '0, nbr_n = '0, nbr_s = '0, nbr_w = '0, nbr_e = '0;
    logic [3:0]   nbr_ok = 4'hF;
    logic         out_valid;
    logic         out_ready = 1'b1;
    logic [3:0]   out_mask;
    logic         out_is_min;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int rdy_mode = 0;
    bit lat_chk = 1'b1;

    logic [4:0] exp_q[$];
    int         cyc_q[$];
    string      tag_q[$];

    logic       prev_stall = 1'b0;
    logic [4:0] prev_out = '0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    steep_mask_unit #(.PIX_W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .centre(centre), .nbr_n(nbr_n), .nbr_s(nbr_s), .nbr_w(nbr_w), .nbr_e(nbr_e),
        .nbr_ok(nbr_ok), .out_valid(out_valid), .out_ready(out_ready),
        .out_mask(out_mask), .out_is_min(out_is_min)
    );

    // returns {mask[3:0], is_min}; mask order {N,S,W,E}
    function automatic logic [4:0] ref_out(int c, int vn, int vs, int vw, int ve, logic [3:0] ok);
        int v[4];
        int best;
        logic [3:0] m;
        v[3] = vn; v[2] = vs; v[1] = vw; v[0] = ve;
        best = 0;
        for (int d = 0; d < 4; d++)
            if (ok[d] && v[d] < c && (c - v[d]) > best) best = c - v[d];
        m = '0;
        for (int d = 0; d < 4; d++)
            if (ok[d] && v[d] < c && (c - v[d]) == best) m[d] = 1'b1;
        return {m, (m == 4'b0000)};
    endfunction

    task automatic check(input bit ok_c, input string tag, input int act, input int exp);
        checks++;
        if (!ok_c) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic set_ready();
        if (rdy_mode == 0) out_ready = 1'b1;
        else               out_ready = (cyc % 3) != 0;
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
        set_ready();
    endtask

    task automatic send(input int c, input int vn, input int vs, input int vw, input int ve,
                        input logic [3:0] ok, input string tag);
        bit done;
        @(negedge clk);
        set_ready();
        in_valid = 1'b1;
        centre = c[W-1:0]; nbr_n = vn[W-1:0]; nbr_s = vs[W-1:0];
        nbr_w = vw[W-1:0]; nbr_e = ve[W-1:0]; nbr_ok = ok;
        done = 1'b0;
        while (!done) begin
            #1;
            if (in_ready) begin
                exp_q.push_back(ref_out(c, vn, vs, vw, ve, ok));
                cyc_q.push_back(cyc);
                tag_q.push_back(tag);
                done = 1'b1;
            end else begin
                @(negedge clk);
                set_ready();
            end
        end
    endtask

    function automatic string class_tag(int c, int vn, int vs, int vw, int ve);
        logic [4:0] r;
        r = ref_out(c, vn, vs, vw, ve, 4'hF);
        if (r[0]) return "R4";
        if ($countones(r[4:1]) > 1) return "R2";
        if (vn == c || vs == c || vw == c || ve == c) return "R5";
        return "R1";
    endfunction

    // output monitor
    always @(negedge clk) begin
        #2;
        if (rst_n) begin
            check(in_ready == (!out_valid || out_ready), "R9", in_ready, !out_valid || out_ready);
            if (prev_stall)
                check(out_valid && {out_mask, out_is_min} == prev_out, "R8",
                      {out_valid, out_mask, out_is_min}, {1'b1, prev_out});
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R8", {out_mask, out_is_min}, 0);
                end else begin
                    logic [4:0] e;
                    int ec;
                    string t;
                    e = exp_q.pop_front();
                    ec = cyc_q.pop_front();
                    t = tag_q.pop_front();
                    check({out_mask, out_is_min} == e, t, {out_mask, out_is_min}, e);
                    if (lat_chk) check(cyc == ec + 2, "R7", cyc - ec, 2);
                end
            end
            prev_stall = out_valid && !out_ready;
            prev_out = {out_mask, out_is_min};
        end
    end

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #2;
        check(out_valid == 1'b0, "R10", out_valid, 0);
        check(in_ready == 1'b1, "R10", in_ready, 1);

        // R3: one lower neighbour per direction, bit position fixed
        send(5, 1, 7, 7, 7, 4'hF, "R3");
        send(5, 7, 1, 7, 7, 4'hF, "R3");
        send(5, 7, 7, 1, 7, 4'hF, "R3");
        send(5, 7, 7, 7, 1, 4'hF, "R3");

        // exhaustive sweep with every neighbour present (R1 R2 R4 R5)
        for (int i = 0; i < MAXV ** 5; i++) begin
            int c, a, b, x, y;
            c = (i >> (4 * W)) % MAXV;
            a = (i >> (3 * W)) % MAXV;
            b = (i >> (2 * W)) % MAXV;
            x = (i >> W) % MAXV;
            y = i % MAXV;
            send(c, a, b, x, y, 4'hF, class_tag(c, a, b, x, y));
        end

        // R6: every presence pattern over a spread of values
        for (int k = 0; k < 16; k++) begin
            for (int j = 0; j < 64; j++)
                send(j % 8, (j * 3) % 8, (j * 5 + 1) % 8, (j * 7 + 2) % 8, j / 8, k[3:0], "R6");
        end

        // R8: backpressure and input gaps
        idle(); idle();
        lat_chk = 1'b0;
        rdy_mode = 1;
        for (int j = 0; j < 2000; j++) begin
            send((j * 7) % 8, (j * 3) % 8, (j / 3) % 8, (j * 5) % 8, (j / 7) % 8,
                 4'((j * 11) % 16), "R8");
            if (j % 5 == 0) idle();
        end
        idle();
        rdy_mode = 0;
        while (exp_q.size() != 0) idle();
        repeat (3) idle();
        check(out_valid == 1'b0, "R8", out_valid, 0);
        finish_run();
    end
endmodule